// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects five interrupt sources and turns them into two request lines for a processor core: one for high-priority service and one for low-priority service. The sources are a timer overflow pulse, a port-change pulse and three asynchronous external pins. Each pin is synchronised and checked for a rising or falling edge, as its edge-select bit chooses. Every source has a flag and an enable. Four sources also have a priority bit. The first external pin has no priority bit and is always high priority.

Software reaches the block through three 8-bit registers on a small synchronous bus with a 2-bit address. Writes take effect at the clock edge. Reads are combinational. A flag is latched whenever its event occurs, even when the source or the global enables are off, so software can poll the flags without interrupts. Only a software write clears a flag. A mode input selects how the two global bits of the main register act. With the mode off, bit 7 is a single global enable and all requests go to the high line. With the mode on, bit 7 gates the high-priority sources and bit 6 gates the low-priority sources.

Register map. Address 0 is the main register: bit 7 global/high enable, bit 6 low enable, bit 5 timer enable, bit 4 ext0 enable, bit 3 port-change enable, bit 2 timer flag, bit 1 ext0 flag, bit 0 port-change flag. Address 1 holds the edge selects and priorities: bit 7 pull-up disable, bit 6 ext0 edge, bit 5 ext1 edge, bit 4 ext2 edge, bit 2 timer priority, bit 0 port-change priority. Address 2 holds the remaining external pins: bit 7 ext2 priority, bit 6 ext1 priority, bit 4 ext2 enable, bit 3 ext1 enable, bit 1 ext2 flag, bit 0 ext1 flag. Address 3 is unused.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x00, address 1 reads 0xF5, address 2 reads 0xC0 and address 3 reads 0x00. Both request lines are low.
- R2: A timer, port-change or external-edge event sets its flag (main bits 2, 0, 1; address 2 bits 0 and 1 for ext1 and ext2) even when every enable bit is 0. With those enables at 0, no request line rises.
- R3: A flag holds until software writes its bit. Writing 0 clears it and writing 1 sets it. An event in the same cycle as a clearing write leaves the flag set.
- R4: An edge-select bit of 1 picks rising edges and 0 picks falling edges. The other edge leaves the flag unchanged. A pin change applied between two clock edges sets its flag at the third rising clock edge after the change.
- R5: Bits 3 and 1 of address 1, bits 5 and 2 of address 2, and all of address 3 read 0 whatever was written to them.
- R6: With the priority mode input low, irq_hi equals main bit 7 AND (any flag whose enable is 1). irq_lo stays 0, and main bit 6 has no effect on either line.
- R7: With the priority mode input high, irq_hi equals main bit 7 AND (any enabled flag whose priority is 1). irq_lo equals main bit 6 AND (any enabled flag whose priority is 0). Priority bits are address 1 bit 2 (timer), address 1 bit 0 (port change), address 2 bit 6 (ext1) and address 2 bit 7 (ext2). Ext0 always counts as priority 1.
- R8: A set flag whose enable is 0 never drives a request line in either mode.
- R9: The pull-up disable output follows address 1 bit 7, which is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prio_mode | input | 1 | 1 = two-level priority mode, 0 = single-level mode |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, acts at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| timer_evt | input | 1 | One-cycle timer overflow pulse |
| portchg_evt | input | 1 | One-cycle port-change pulse |
| ext_pin | input | 3 | Asynchronous external interrupt pins ext0..ext2 |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |
| pullup_dis | output | 1 | Pull-up disable control |

## Verification
A wrong flag or enable bit shows at the ports in two ways. A read of the register returns the wrong value, and the request lines change in the same cycle because they decode the registered state combinationally. A fault in the pin path shows as a flag that appears one or more cycles early or late, or on the wrong edge. The bench therefore samples flags at exactly the second and third clock edges after each pin change. Mode faults show as a request on the wrong line or gated by the wrong global bit, so each global bit is toggled alone in both modes.

// File: rtl/prio_irq_pkg.sv
// Shared constants and types for the two-level interrupt controller.
// Assumes an 8-bit register width and five sources in a fixed order.
package prio_irq_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int N_EXT  = 3;
    localparam int N_SRC  = N_EXT + 2;

    // Source index order inside the internal flag/enable vectors
    localparam int IDX_TMR = 0;
    localparam int IDX_X0  = 1;
    localparam int IDX_X1  = 2;
    localparam int IDX_X2  = 3;
    localparam int IDX_PC  = 4;

    // Register selector decoded from the bus address
    typedef enum logic [ADDR_W-1:0] {
        SEL_MAIN = 2'd0,
        SEL_EDGE = 2'd1,
        SEL_AUX  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Bit positions in the main register
    localparam int M_GHI  = 7;
    localparam int M_GLO  = 6;
    localparam int M_TEN  = 5;
    localparam int M_X0EN = 4;
    localparam int M_PCEN = 3;
    localparam int M_TFL  = 2;
    localparam int M_X0FL = 1;
    localparam int M_PCFL = 0;

    // Bit positions in the edge/priority register
    localparam int E_PUD  = 7;
    localparam int E_X0ED = 6;   // ext1 at 5, ext2 at 4
    localparam int E_TPRI = 2;
    localparam int E_PPRI = 0;

    // Bit positions in the auxiliary register
    localparam int A_X2PRI = 7;
    localparam int A_X1PRI = 6;
    localparam int A_X2EN  = 4;
    localparam int A_X1EN  = 3;
    localparam int A_X2FL  = 1;
    localparam int A_X1FL  = 0;

    // Gate inputs handed from the register bank to the request logic
    typedef struct packed {
        logic             glb_hi;
        logic             glb_lo;
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] pri;
        logic [N_SRC-1:0] flag;
    } irq_gate_t;

endpackage

// File: rtl/prio_irq_pin_edge.sv
// Synchronises one asynchronous pin and emits a one-cycle pulse on the
// selected edge. Assumes SYNC_STAGES >= 2 and a pin held low at reset.
module prio_irq_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_sel,
    output logic edge_pulse
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         last_q;

    // Shift the pin through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[TOP-1:0], pin_async};
        end
    end

    // Hold the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[TOP];
        end
    end

    // Pick the rising or falling transition as the select bit asks
    always_comb begin
        if (rise_sel) begin
            edge_pulse = sync_q[TOP] & ~last_q;
        end else begin
            edge_pulse = ~sync_q[TOP] & last_q;
        end
    end

endmodule

// File: rtl/prio_irq_regs.sv
// Register bank: the three control registers, flag latching and read mux.
// Assumes single-cycle write strobes. An event overrides a clearing write.
module prio_irq_regs
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [N_SRC-1:0]  src_evt,
    output logic [N_EXT-1:0]  edge_rise,
    output logic              pullup_dis,
    output irq_gate_t         gate
);
    reg_sel_e         sel;
    logic             glb_hi_q, glb_lo_q, pud_q;
    logic [N_SRC-1:0] en_q, flag_q, pri_q;
    logic [N_EXT-1:0] edge_q;
    logic [N_SRC-1:0] fl_mask, fl_val, flag_d;

    assign sel = reg_sel_e'(bus_addr);

    // Control fields of the main register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_hi_q <= 1'b0;
            glb_lo_q <= 1'b0;
        end else if (bus_wr && sel == SEL_MAIN) begin
            glb_hi_q <= bus_wdata[M_GHI];
            glb_lo_q <= bus_wdata[M_GLO];
        end
    end

    // Per-source enables, written from two registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (bus_wr && sel == SEL_MAIN) begin
            en_q[IDX_TMR] <= bus_wdata[M_TEN];
            en_q[IDX_X0]  <= bus_wdata[M_X0EN];
            en_q[IDX_PC]  <= bus_wdata[M_PCEN];
        end else if (bus_wr && sel == SEL_AUX) begin
            en_q[IDX_X1]  <= bus_wdata[A_X1EN];
            en_q[IDX_X2]  <= bus_wdata[A_X2EN];
        end
    end

    // Pull-up disable and edge selects (edge register)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pud_q  <= 1'b1;
            edge_q <= '1;
        end else if (bus_wr && sel == SEL_EDGE) begin
            pud_q <= bus_wdata[E_PUD];
            for (int i = 0; i < N_EXT; i++) begin
                edge_q[i] <= bus_wdata[E_X0ED - i];
            end
        end
    end

    // Priority bits; ext0 has none and is tied high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= '1;
        end else if (bus_wr && sel == SEL_EDGE) begin
            pri_q[IDX_TMR] <= bus_wdata[E_TPRI];
            pri_q[IDX_PC]  <= bus_wdata[E_PPRI];
        end else if (bus_wr && sel == SEL_AUX) begin
            pri_q[IDX_X1]  <= bus_wdata[A_X1PRI];
            pri_q[IDX_X2]  <= bus_wdata[A_X2PRI];
        end
    end

    // Which flags a write touches and with what value
    always_comb begin
        fl_mask = '0;
        fl_val  = '0;
        if (bus_wr && sel == SEL_MAIN) begin
            fl_mask[IDX_TMR] = 1'b1;
            fl_mask[IDX_X0]  = 1'b1;
            fl_mask[IDX_PC]  = 1'b1;
            fl_val[IDX_TMR]  = bus_wdata[M_TFL];
            fl_val[IDX_X0]   = bus_wdata[M_X0FL];
            fl_val[IDX_PC]   = bus_wdata[M_PCFL];
        end else if (bus_wr && sel == SEL_AUX) begin
            fl_mask[IDX_X1]  = 1'b1;
            fl_mask[IDX_X2]  = 1'b1;
            fl_val[IDX_X1]   = bus_wdata[A_X1FL];
            fl_val[IDX_X2]   = bus_wdata[A_X2FL];
        end
        flag_d = (flag_q & ~fl_mask) | (fl_val & fl_mask) | src_evt;
    end

    // Flag storage: events set, software writes, hardware never clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    // Read multiplexer; unimplemented bits return 0
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_MAIN: begin
                bus_rdata[M_GHI]  = glb_hi_q;
                bus_rdata[M_GLO]  = glb_lo_q;
                bus_rdata[M_TEN]  = en_q[IDX_TMR];
                bus_rdata[M_X0EN] = en_q[IDX_X0];
                bus_rdata[M_PCEN] = en_q[IDX_PC];
                bus_rdata[M_TFL]  = flag_q[IDX_TMR];
                bus_rdata[M_X0FL] = flag_q[IDX_X0];
                bus_rdata[M_PCFL] = flag_q[IDX_PC];
            end
            SEL_EDGE: begin
                bus_rdata[E_PUD]  = pud_q;
                for (int i = 0; i < N_EXT; i++) begin
                    bus_rdata[E_X0ED - i] = edge_q[i];
                end
                bus_rdata[E_TPRI] = pri_q[IDX_TMR];
                bus_rdata[E_PPRI] = pri_q[IDX_PC];
            end
            SEL_AUX: begin
                bus_rdata[A_X2PRI] = pri_q[IDX_X2];
                bus_rdata[A_X1PRI] = pri_q[IDX_X1];
                bus_rdata[A_X2EN]  = en_q[IDX_X2];
                bus_rdata[A_X1EN]  = en_q[IDX_X1];
                bus_rdata[A_X2FL]  = flag_q[IDX_X2];
                bus_rdata[A_X1FL]  = flag_q[IDX_X1];
            end
            default: bus_rdata = '0;
        endcase
    end

    assign edge_rise   = edge_q;
    assign pullup_dis  = pud_q;
    assign gate.glb_hi = glb_hi_q;
    assign gate.glb_lo = glb_lo_q;
    assign gate.en     = en_q;
    assign gate.pri    = pri_q;
    assign gate.flag   = flag_q;

endmodule

// File: rtl/prio_irq_req.sv
// Combines registered flags, enables, priorities and the global bits into
// the two request lines. Purely combinational; the mode input picks the meaning.
module prio_irq_req
    import prio_irq_pkg::*;
(
    input  logic      prio_mode,
    input  irq_gate_t gate,
    output logic      irq_hi,
    output logic      irq_lo
);
    logic [N_SRC-1:0] pend;
    logic             any_pend, hi_pend, lo_pend;

    // Pending = flagged and enabled, split by priority
    always_comb begin
        pend     = gate.flag & gate.en;
        any_pend = |pend;
        hi_pend  = |(pend & gate.pri);
        lo_pend  = |(pend & ~gate.pri);
    end

    // Drive the lines according to the priority mode
    always_comb begin
        if (prio_mode) begin
            irq_hi = gate.glb_hi & hi_pend;
            irq_lo = gate.glb_lo & lo_pend;
        end else begin
            irq_hi = gate.glb_hi & any_pend;
            irq_lo = 1'b0;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Top level of the two-level interrupt controller. Instantiates one edge
// detector per external pin, the register bank and the request logic.
// Assumes event pulses are synchronous to clk and one cycle wide.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              timer_evt,
    input  logic              portchg_evt,
    input  logic [N_EXT-1:0]  ext_pin,
    output logic              irq_hi,
    output logic              irq_lo,
    output logic              pullup_dis
);
    logic [N_EXT-1:0] edge_rise;
    logic [N_EXT-1:0] ext_evt;
    logic [N_SRC-1:0] src_evt;
    irq_gate_t        gate;
    logic [N_SRC-1:0] flag_q;
    logic             glb_hi, glb_lo;

    // One synchroniser and edge detector per external pin
    for (genvar g = 0; g < N_EXT; g++) begin : g_pin
        prio_irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_async  (ext_pin[g]),
            .rise_sel   (edge_rise[g]),
            .edge_pulse (ext_evt[g])
        );
    end

    // Gather the event pulses in source-index order
    always_comb begin
        src_evt          = '0;
        src_evt[IDX_TMR] = timer_evt;
        src_evt[IDX_X0]  = ext_evt[0];
        src_evt[IDX_X1]  = ext_evt[1];
        src_evt[IDX_X2]  = ext_evt[2];
        src_evt[IDX_PC]  = portchg_evt;
    end

    prio_irq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .src_evt    (src_evt),
        .edge_rise  (edge_rise),
        .pullup_dis (pullup_dis),
        .gate       (gate)
    );

    prio_irq_req u_req (
        .prio_mode (prio_mode),
        .gate      (gate),
        .irq_hi    (irq_hi),
        .irq_lo    (irq_lo)
    );

    assign flag_q = gate.flag;
    assign glb_hi = gate.glb_hi;
    assign glb_lo = gate.glb_lo;

endmodule

// File: rtl/prio_irq_chk.sv
// Property checker for the interrupt controller, attached to the top by bind.
// Observes ports plus the register-bank state that feeds the request logic.
module prio_irq_chk
    import prio_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             prio_mode,
    input logic             bus_wr,
    input logic             timer_evt,
    input logic             portchg_evt,
    input logic [N_SRC-1:0] flag_q,
    input logic             glb_hi,
    input logic             glb_lo,
    input logic             irq_hi,
    input logic             irq_lo
);
    // R2: a timer pulse always leaves its flag set on the next cycle
    assert_tmr_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(timer_evt && rst_n) |-> flag_q[IDX_TMR]);

    // R2: a port-change pulse always leaves its flag set on the next cycle
    assert_pc_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(portchg_evt && rst_n) |-> flag_q[IDX_PC]);

    // R3: no flag falls without a software write in the cycle before
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flag_q) & ~flag_q)) |-> $past(bus_wr));

    // R6: the low line stays quiet in single-level mode
    assert_lo_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_mode |-> !irq_lo);

    // R6 and R7: the high line needs bit 7 of the main register
    assert_hi_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> glb_hi);

    // R7: in priority mode the low line needs bit 6 of the main register
    assert_lo_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_mode && irq_lo) |-> glb_lo);

    // R8: no request line is up while every flag is clear
    assert_no_req_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0) |-> (!irq_hi && !irq_lo));

endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prio_mode   (prio_mode),
    .bus_wr      (bus_wr),
    .timer_evt   (timer_evt),
    .portchg_evt (portchg_evt),
    .flag_q      (flag_q),
    .glb_hi      (glb_hi),
    .glb_lo      (glb_lo),
    .irq_hi      (irq_hi),
    .irq_lo      (irq_lo)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
// Directed bench for the two-level interrupt controller.
module tb_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prio_mode = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       timer_evt = 1'b0;
    logic       portchg_evt = 1'b0;
    logic [2:0] ext_pin = 3'b000;
    logic       irq_hi, irq_lo, pullup_dis;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .prio_mode   (prio_mode),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .timer_evt   (timer_evt),
        .portchg_evt (portchg_evt),
        .ext_pin     (ext_pin),
        .irq_hi      (irq_hi),
        .irq_lo      (irq_lo),
        .pullup_dis  (pullup_dis)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    task automatic req_check(input string tag, input logic hi, input logic lo);
        #0.5;
        check({tag, " irq_hi"}, {7'd0, irq_hi}, {7'd0, hi});
        check({tag, " irq_lo"}, {7'd0, irq_lo}, {7'd0, lo});
    endtask

    task automatic pulse_timer();
        @(negedge clk); timer_evt = 1'b1;
        @(negedge clk); timer_evt = 1'b0;
    endtask

    task automatic pulse_pc();
        @(negedge clk); portchg_evt = 1'b1;
        @(negedge clk); portchg_evt = 1'b0;
    endtask

    // Drive a pin level and wait three clock edges for the flag
    task automatic set_pin(input int idx, input logic v);
        @(negedge clk); ext_pin[idx] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_all();
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'hF5);
        wr_reg(2'd2, 8'hC0);
    endtask

    task automatic t_reset();
        rd_check("R1 reset main", 2'd0, 8'h00);
        rd_check("R1 reset edge", 2'd1, 8'hF5);
        rd_check("R1 reset aux",  2'd2, 8'hC0);
        rd_check("R1 reset unused", 2'd3, 8'h00);
        req_check("R1 reset", 1'b0, 1'b0);
        check("R9 pullup reset", {7'd0, pullup_dis}, 8'h01);
    endtask

    task automatic t_poll();
        clear_all();
        wr_reg(2'd0, 8'h80);            // global on, no source enables
        pulse_timer();
        rd_check("R2 timer flag", 2'd0, 8'h84);
        req_check("R2 disabled timer", 1'b0, 1'b0);
        pulse_pc();
        rd_check("R2 pc flag", 2'd0, 8'h85);
        set_pin(0, 1'b1);
        rd_check("R2 ext0 flag", 2'd0, 8'h87);
        set_pin(2, 1'b1);
        rd_check("R2 ext2 flag", 2'd2, 8'hC2);
        req_check("R8 flags without enables", 1'b0, 1'b0);
        set_pin(0, 1'b0);
        set_pin(2, 1'b0);
    endtask

    task automatic t_sticky();
        clear_all();
        pulse_timer();
        repeat (5) @(negedge clk);
        rd_check("R3 flag holds", 2'd0, 8'h04);
        wr_reg(2'd0, 8'h00);
        rd_check("R3 write 0 clears", 2'd0, 8'h00);
        wr_reg(2'd0, 8'h01);
        rd_check("R3 write 1 sets", 2'd0, 8'h01);
        wr_reg(2'd0, 8'h00);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1'b1; timer_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; timer_evt = 1'b0;
        rd_check("R3 event beats clear", 2'd0, 8'h04);
    endtask

    task automatic t_edges();
        clear_all();
        @(negedge clk); ext_pin[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_check("R4 not before third edge", 2'd2, 8'hC0);
        @(negedge clk);
        rd_check("R4 rising at third edge", 2'd2, 8'hC1);
        wr_reg(2'd2, 8'hC0);
        set_pin(1, 1'b0);
        rd_check("R4 falling ignored in rise mode", 2'd2, 8'hC0);
        wr_reg(2'd1, 8'hD5);            // ext1 edge select -> falling
        set_pin(1, 1'b1);
        rd_check("R4 rising ignored in fall mode", 2'd2, 8'hC0);
        set_pin(1, 1'b0);
        rd_check("R4 falling caught", 2'd2, 8'hC1);
    endtask

    task automatic t_unused();
        wr_reg(2'd1, 8'hFF);
        rd_check("R5 edge reg holes", 2'd1, 8'hF5);
        wr_reg(2'd2, 8'hFF);
        rd_check("R5 aux reg holes", 2'd2, 8'hDB);
        wr_reg(2'd3, 8'hFF);
        rd_check("R5 address 3", 2'd3, 8'h00);
        clear_all();
    endtask

    task automatic t_single();
        prio_mode = 1'b0;
        clear_all();
        wr_reg(2'd0, 8'hA4);
        req_check("R6 enabled timer", 1'b1, 1'b0);
        wr_reg(2'd0, 8'h24);
        req_check("R6 global off", 1'b0, 1'b0);
        wr_reg(2'd0, 8'h64);
        req_check("R6 bit6 no effect", 1'b0, 1'b0);
        wr_reg(2'd0, 8'hE4);
        req_check("R6 bit6 with global", 1'b1, 1'b0);
        wr_reg(2'd1, 8'hF1);            // timer priority low: still high line here
        req_check("R6 low prio ignored", 1'b1, 1'b0);
        wr_reg(2'd0, 8'h84);
        req_check("R8 flag not enabled", 1'b0, 1'b0);
    endtask

    task automatic t_dual();
        clear_all();
        @(negedge clk); prio_mode = 1'b1;
        wr_reg(2'd1, 8'hF1);            // timer priority low
        wr_reg(2'd0, 8'hA4);
        req_check("R7 low source, bit6 off", 1'b0, 1'b0);
        wr_reg(2'd0, 8'h64);
        req_check("R7 low source, bit6 on", 1'b0, 1'b1);
        wr_reg(2'd0, 8'h92);
        req_check("R7 ext0 high", 1'b1, 1'b0);
        wr_reg(2'd0, 8'h52);
        req_check("R7 ext0 not low", 1'b0, 1'b0);
        wr_reg(2'd2, 8'h49);            // ext2 low prio, ext1 enabled+flag high
        wr_reg(2'd0, 8'hC0);
        req_check("R7 ext1 high", 1'b1, 1'b0);
        wr_reg(2'd2, 8'h13);            // ext1 low, ext2 enabled+flag low
        req_check("R7 ext2 low", 1'b0, 1'b1);
        wr_reg(2'd2, 8'h03);            // flags set, no enables
        req_check("R8 aux flags disabled", 1'b0, 1'b0);
        @(negedge clk); prio_mode = 1'b0;
        clear_all();
    endtask

    task automatic t_pullup();
        wr_reg(2'd1, 8'h75);
        #0.5;
        check("R9 pullup cleared", {7'd0, pullup_dis}, 8'h00);
        wr_reg(2'd1, 8'hF5);
        #0.5;
        check("R9 pullup set", {7'd0, pullup_dis}, 8'h01);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_poll();
        t_sticky();
        t_edges();
        t_unused();
        t_single();
        t_dual();
        t_pullup();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule